// File: doc/BRIEF.md
# Transaction-Counting Phase Barrier

This block holds one hardware barrier object. It follows a phase number, the number of arrivals still awaited in the current phase, the number of arrivals expected in each new phase, and a count of outstanding transactions such as bytes still in flight. A phase closes only when the awaited arrivals and the outstanding transactions are both at zero. When a phase closes, the phase number steps by one and the awaited count reloads from the expected count, all in the same cycle.

Agents send one command per cycle. They can arm the object, disarm it, arrive, arrive and permanently leave, announce transactions, retire transactions, or combine an announcement with a single arrival. Each arrival returns a token holding the phase number before that arrival. A combinational test port takes either a phase parity or such a token and reports whether the phase it names has closed. The agent polls this port until it reads true.

Top module: `phase_barrier`

## Requirements
- R1: Command code 1 (arm) with a count in the range 1 to 2^ARR_W-1 on a disarmed object makes it valid. It clears the phase and the transaction count and loads both the expected and the awaited counts with the count.
- R2: Command code 3 (arrive) lowers the awaited count by the low ARR_W bits of the count operand.
- R3: Command code 5 raises the transaction count by the full 32-bit operand. Command code 6 lowers it by the same operand.
- R4: A phase does not close while the transaction count is nonzero, even if the awaited count is zero.
- R5: When a command leaves both the awaited count and the transaction count at zero, the phase steps by one, the awaited count reloads from the expected count, and phase_done_o pulses for one cycle.
- R6: Command code 4 (arrive and leave) lowers the expected count by its operand and then arrives with the same operand.
- R7: Command code 7 adds the operand to the transaction count and then arrives once. Command code 8 does the same and also lowers the expected count by one.
- R8: Every arriving command (codes 3, 4, 7, 8) pulses token_vld_o and places the phase number from before the command on token_o.
- R9: With test_by_token_i=0, test_done_o is 1 when test_parity_i differs from bit 0 of the current phase, because that phase is the one just closed. With test_by_token_i=1, test_done_o is 1 when test_token_i differs from the current phase. test_done_o is 0 while the object is disarmed.
- R10: The following raise err_o for one cycle and leave all state unchanged: an arm on a valid object, an arm with count 0, any other command on a disarmed object, and an unknown code (9 to 15). Command code 2 (disarm) clears valid. Code 0 does nothing.
- R11: A lowering that would go below zero clamps the counter at zero and pulses uflow_o.
- R12: Within one command the expected-count update happens first, then the transaction update, then the arrival, then the close check. A reload therefore uses the already-lowered expected count.
- R13: Synchronous reset leaves the object disarmed with all counters, the phase and all flags at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | A command is presented this cycle |
| cmd_op_i | input | 4 | Command code |
| cmd_count_i | input | TX_W | Count operand |
| test_by_token_i | input | 1 | 1 = test by token, 0 = test by parity |
| test_parity_i | input | 1 | Parity of the phase under test |
| test_token_i | input | PH_W | Token under test |
| test_done_o | output | 1 | The tested phase has closed |
| valid_o | output | 1 | Object is armed |
| phase_o | output | PH_W | Current phase number |
| pending_o | output | ARR_W | Awaited arrivals |
| expected_o | output | ARR_W | Expected arrivals per phase |
| tx_o | output | TX_W | Outstanding transactions |
| token_o | output | PH_W | Phase before the last arrival |
| token_vld_o | output | 1 | Pulse: token_o was just updated |
| phase_done_o | output | 1 | Pulse: a phase closed |
| err_o | output | 1 | Pulse: illegal command |
| uflow_o | output | 1 | Pulse: a counter was clamped at zero |

## Verification
A scripted sequence first drives the arrival count to zero while transactions are still outstanding. This separates a close that waits on both counters from one that waits only on arrivals. A close triggered by the last transaction retirement, and one triggered by the last arrival, show that either counter can be the one that ends a phase. Combined arrive-and-leave commands whose close must reload the lowered expected count show whether the updates within a cycle happen in the required order. Oversized retirements and arrivals, illegal arm and disarm sequences, and parity and token tests taken before and after a close test the clamping, the error path and both test modes.

// File: rtl/pb_pkg.sv
package pb_pkg;

    typedef enum logic [3:0] {
        PB_NOP            = 4'd0,
        PB_ARM            = 4'd1,
        PB_DISARM         = 4'd2,
        PB_ARRIVE         = 4'd3,
        PB_ARRIVE_LEAVE   = 4'd4,
        PB_TX_ADD         = 4'd5,
        PB_TX_SUB         = 4'd6,
        PB_ARRIVE_TX      = 4'd7,
        PB_ARRIVE_LEAVE_TX = 4'd8
    } pb_cmd_e;

    // Control word decoded from one command
    typedef struct packed {
        logic nop;
        logic arm;
        logic disarm;
        logic leave;     // lower expected count
        logic tx_add;
        logic tx_sub;
        logic arrive;
        logic unit;      // arrival / leave amount is exactly 1
        logic known;
    } pb_ctl_t;

endpackage

// File: rtl/pb_decode.sv
module pb_decode
    import pb_pkg::*;
(
    input  logic [3:0] op_i,
    output pb_ctl_t    ctl_o
);
    always_comb begin
        ctl_o       = '0;
        ctl_o.known = 1'b1;
        case (pb_cmd_e'(op_i))
            PB_NOP:             ctl_o.nop = 1'b1;
            PB_ARM:             ctl_o.arm = 1'b1;
            PB_DISARM:          ctl_o.disarm = 1'b1;
            PB_ARRIVE:          ctl_o.arrive = 1'b1;
            PB_ARRIVE_LEAVE: begin
                ctl_o.leave  = 1'b1;
                ctl_o.arrive = 1'b1;
            end
            PB_TX_ADD:          ctl_o.tx_add = 1'b1;
            PB_TX_SUB:          ctl_o.tx_sub = 1'b1;
            PB_ARRIVE_TX: begin
                ctl_o.tx_add = 1'b1;
                ctl_o.arrive = 1'b1;
                ctl_o.unit   = 1'b1;
            end
            PB_ARRIVE_LEAVE_TX: begin
                ctl_o.tx_add = 1'b1;
                ctl_o.leave  = 1'b1;
                ctl_o.arrive = 1'b1;
                ctl_o.unit   = 1'b1;
            end
            default:            ctl_o.known = 1'b0;
        endcase
    end
endmodule

// File: rtl/pb_sat_sub.sv
module pb_sat_sub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o,
    output logic         clamp_o
);
    always_comb begin
        clamp_o = (b_i > a_i);
        y_o     = clamp_o ? '0 : (a_i - b_i);
    end
endmodule

// File: rtl/pb_phase_test.sv
module pb_phase_test #(
    parameter int PH_W = 8
) (
    input  logic            armed_i,
    input  logic [PH_W-1:0] phase_i,
    input  logic            by_token_i,
    input  logic            parity_i,
    input  logic [PH_W-1:0] token_i,
    output logic            done_o
);
    logic closed;
    always_comb begin
        if (by_token_i)
            closed = (token_i != phase_i);
        else
            closed = (parity_i != phase_i[0]);
        done_o = armed_i & closed;
    end
endmodule

// File: rtl/phase_barrier.sv
module phase_barrier
    import pb_pkg::*;
#(
    parameter int ARR_W = 20,
    parameter int TX_W  = 32,
    parameter int PH_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid_i,
    input  logic [3:0]       cmd_op_i,
    input  logic [TX_W-1:0]  cmd_count_i,
    input  logic             test_by_token_i,
    input  logic             test_parity_i,
    input  logic [PH_W-1:0]  test_token_i,
    output logic             test_done_o,
    output logic             valid_o,
    output logic [PH_W-1:0]  phase_o,
    output logic [ARR_W-1:0] pending_o,
    output logic [ARR_W-1:0] expected_o,
    output logic [TX_W-1:0]  tx_o,
    output logic [PH_W-1:0]  token_o,
    output logic             token_vld_o,
    output logic             phase_done_o,
    output logic             err_o,
    output logic             uflow_o
);
    localparam logic [ARR_W-1:0] ARR_ONE = ARR_W'(1);
    localparam int               HI_W    = TX_W - ARR_W;

    pb_ctl_t ctl;

    logic [ARR_W-1:0] amt;
    logic [ARR_W-1:0] leave_amt, arr_amt;
    logic [ARR_W-1:0] exp_d, pend_d;
    logic [TX_W:0]    tx_sum;
    logic [TX_W-1:0]  tx_mid, tx_sub_amt, tx_d;
    logic             c_exp, c_tx, c_pend;
    logic             arm_ok, disarm_ok, accept, illegal, closes;

    pb_decode u_dec (
        .op_i  (cmd_op_i),
        .ctl_o (ctl)
    );

    // Operand shaping, in the required order: expected, transactions, arrivals
    always_comb begin
        amt        = ctl.unit ? ARR_ONE : cmd_count_i[ARR_W-1:0];
        leave_amt  = ctl.leave  ? amt : '0;
        arr_amt    = ctl.arrive ? amt : '0;
        tx_sum     = {1'b0, tx_o} + {1'b0, (ctl.tx_add ? cmd_count_i : '0)};
        tx_mid     = tx_sum[TX_W] ? '1 : tx_sum[TX_W-1:0];
        tx_sub_amt = ctl.tx_sub ? cmd_count_i : '0;
    end

    pb_sat_sub #(.W(ARR_W)) u_exp_sub (
        .a_i(expected_o), .b_i(leave_amt), .y_o(exp_d), .clamp_o(c_exp)
    );
    pb_sat_sub #(.W(TX_W)) u_tx_sub (
        .a_i(tx_mid), .b_i(tx_sub_amt), .y_o(tx_d), .clamp_o(c_tx)
    );
    pb_sat_sub #(.W(ARR_W)) u_pend_sub (
        .a_i(pending_o), .b_i(arr_amt), .y_o(pend_d), .clamp_o(c_pend)
    );

    always_comb begin
        arm_ok    = cmd_valid_i && ctl.arm && !valid_o &&
                    (cmd_count_i[TX_W-1:ARR_W] == HI_W'(0)) &&
                    (cmd_count_i[ARR_W-1:0] != '0);
        disarm_ok = cmd_valid_i && ctl.disarm && valid_o;
        accept    = cmd_valid_i && valid_o && ctl.known && !ctl.nop &&
                    !ctl.arm && !ctl.disarm;
        illegal   = cmd_valid_i && !ctl.nop && !arm_ok && !disarm_ok && !accept;
        closes    = accept && (pend_d == '0) && (tx_d == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o      <= 1'b0;
            phase_o      <= '0;
            pending_o    <= '0;
            expected_o   <= '0;
            tx_o         <= '0;
            token_o      <= '0;
            token_vld_o  <= 1'b0;
            phase_done_o <= 1'b0;
            err_o        <= 1'b0;
            uflow_o      <= 1'b0;
        end else begin
            err_o        <= illegal;
            uflow_o      <= accept && (c_exp || c_tx || c_pend);
            phase_done_o <= closes;
            token_vld_o  <= accept && ctl.arrive;
            if (accept && ctl.arrive)
                token_o <= phase_o;
            if (arm_ok) begin
                valid_o    <= 1'b1;
                phase_o    <= '0;
                tx_o       <= '0;
                expected_o <= cmd_count_i[ARR_W-1:0];
                pending_o  <= cmd_count_i[ARR_W-1:0];
            end else if (disarm_ok) begin
                valid_o <= 1'b0;
            end else if (accept) begin
                expected_o <= exp_d;
                tx_o       <= tx_d;
                if (closes) begin
                    phase_o   <= phase_o + PH_W'(1);
                    pending_o <= exp_d;
                end else begin
                    pending_o <= pend_d;
                end
            end
        end
    end

    pb_phase_test #(.PH_W(PH_W)) u_test (
        .armed_i   (valid_o),
        .phase_i   (phase_o),
        .by_token_i(test_by_token_i),
        .parity_i  (test_parity_i),
        .token_i   (test_token_i),
        .done_o    (test_done_o)
    );
endmodule

// File: rtl/pb_checker.sv
module pb_checker #(
    parameter int ARR_W = 20,
    parameter int TX_W  = 32,
    parameter int PH_W  = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             valid_o,
    input logic [PH_W-1:0]  phase_o,
    input logic [ARR_W-1:0] pending_o,
    input logic [ARR_W-1:0] expected_o,
    input logic [TX_W-1:0]  tx_o,
    input logic             token_vld_o,
    input logic             phase_done_o,
    input logic             err_o
);
    // R5
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_o != $past(phase_o)) |->
            ((phase_o == $past(phase_o) + PH_W'(1)) || $rose(valid_o)));

    // R5
    close_reload_chk: assert property (@(posedge clk) disable iff (rst)
        phase_done_o |-> ((pending_o == expected_o) && (tx_o == '0)));

    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> ($stable(phase_o) && $stable(pending_o) && $stable(expected_o)
                   && $stable(tx_o) && $stable(valid_o)));

    // R8
    token_armed_chk: assert property (@(posedge clk) disable iff (rst)
        token_vld_o |-> valid_o);

    // R1
    arm_state_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_o) |-> ((phase_o == '0) && (tx_o == '0) && (pending_o == expected_o)));
endmodule

bind phase_barrier pb_checker #(.ARR_W(ARR_W), .TX_W(TX_W), .PH_W(PH_W)) u_chk (
    .clk(clk), .rst(rst), .valid_o(valid_o), .phase_o(phase_o),
    .pending_o(pending_o), .expected_o(expected_o), .tx_o(tx_o),
    .token_vld_o(token_vld_o), .phase_done_o(phase_done_o), .err_o(err_o)
);

// File: tb/phase_barrier_tb.sv
module phase_barrier_tb;
    localparam int ARR_W = 20;
    localparam int TX_W  = 32;
    localparam int PH_W  = 8;
    localparam int NV    = 18;

    typedef struct packed {
        logic [3:0]       op;
        logic [31:0]      cnt;
        logic [7:0]       phase;
        logic [19:0]      pend;
        logic [19:0]      expc;
        logic [31:0]      tx;
        logic             vld;
        logic             err;
        logic             uf;
        logic             done;
    } vec_t;

    // op, count, phase, pending, expected, tx, valid, err, uflow, close
    localparam vec_t VEC [NV] = '{
        '{4'd1, 32'd3,   8'd0, 20'd3, 20'd3, 32'd0,   1'b1, 1'b0, 1'b0, 1'b0},
        '{4'd3, 32'd1,   8'd0, 20'd2, 20'd3, 32'd0,   1'b1, 1'b0, 1'b0, 1'b0},
        '{4'd5, 32'd100, 8'd0, 20'd2, 20'd3, 32'd100, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'd3, 32'd2,   8'd0, 20'd0, 20'd3, 32'd100, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'd6, 32'd60,  8'd0, 20'd0, 20'd3, 32'd40,  1'b1, 1'b0, 1'b0, 1'b0},
        '{4'd6, 32'd40,  8'd1, 20'd3, 20'd3, 32'd0,   1'b1, 1'b0, 1'b0, 1'b1},
        '{4'd7, 32'd10,  8'd1, 20'd2, 20'd3, 32'd10,  1'b1, 1'b0, 1'b0, 1'b0},
        '{4'd4, 32'd1,   8'd1, 20'd1, 20'd2, 32'd10,  1'b1, 1'b0, 1'b0, 1'b0},
        '{4'd8, 32'd5,   8'd1, 20'd0, 20'd1, 32'd15,  1'b1, 1'b0, 1'b0, 1'b0},
        '{4'd6, 32'd20,  8'd2, 20'd1, 20'd1, 32'd0,   1'b1, 1'b0, 1'b1, 1'b1},
        '{4'd3, 32'd3,   8'd3, 20'd1, 20'd1, 32'd0,   1'b1, 1'b0, 1'b1, 1'b1},
        '{4'd1, 32'd5,   8'd3, 20'd1, 20'd1, 32'd0,   1'b1, 1'b1, 1'b0, 1'b0},
        '{4'd2, 32'd0,   8'd3, 20'd1, 20'd1, 32'd0,   1'b0, 1'b0, 1'b0, 1'b0},
        '{4'd3, 32'd1,   8'd3, 20'd1, 20'd1, 32'd0,   1'b0, 1'b1, 1'b0, 1'b0},
        '{4'd1, 32'd0,   8'd3, 20'd1, 20'd1, 32'd0,   1'b0, 1'b1, 1'b0, 1'b0},
        '{4'd1, 32'd4,   8'd0, 20'd4, 20'd4, 32'd0,   1'b1, 1'b0, 1'b0, 1'b0},
        '{4'd3, 32'd3,   8'd0, 20'd1, 20'd4, 32'd0,   1'b1, 1'b0, 1'b0, 1'b0},
        '{4'd4, 32'd1,   8'd1, 20'd3, 20'd3, 32'd0,   1'b1, 1'b0, 1'b0, 1'b1}
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 15:     return "R1";
            1:         return "R2";
            2, 4:      return "R3";
            3:         return "R4";
            5:         return "R5";
            6:         return "R7";
            7:         return "R6";
            8:         return "R7/R12";
            9, 10:     return "R11";
            16, 17:    return "R12";
            default:   return "R10";
        endcase
    endfunction

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_valid_i = 1'b0;
    logic [3:0]       cmd_op_i = '0;
    logic [TX_W-1:0]  cmd_count_i = '0;
    logic             test_by_token_i = 1'b0;
    logic             test_parity_i = 1'b0;
    logic [PH_W-1:0]  test_token_i = '0;
    logic             test_done_o, valid_o, token_vld_o, phase_done_o, err_o, uflow_o;
    logic [PH_W-1:0]  phase_o, token_o;
    logic [ARR_W-1:0] pending_o, expected_o;
    logic [TX_W-1:0]  tx_o;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    phase_barrier #(.ARR_W(ARR_W), .TX_W(TX_W), .PH_W(PH_W)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
        .cmd_count_i(cmd_count_i), .test_by_token_i(test_by_token_i),
        .test_parity_i(test_parity_i), .test_token_i(test_token_i),
        .test_done_o(test_done_o), .valid_o(valid_o), .phase_o(phase_o),
        .pending_o(pending_o), .expected_o(expected_o), .tx_o(tx_o),
        .token_o(token_o), .token_vld_o(token_vld_o), .phase_done_o(phase_done_o),
        .err_o(err_o), .uflow_o(uflow_o)
    );

    task automatic check(string tag, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Drive one command; returns one step after the capturing edge
    task automatic issue(logic [3:0] op, logic [31:0] cnt);
        @(negedge clk);
        cmd_valid_i = 1'b1;
        cmd_op_i    = op;
        cmd_count_i = cnt;
        @(posedge clk);
        #1;
        cmd_valid_i = 1'b0;
        cmd_op_i    = '0;
        cmd_count_i = '0;
    endtask

    task automatic probe(logic by_tok, logic par, logic [PH_W-1:0] tok);
        @(negedge clk);
        test_by_token_i = by_tok;
        test_parity_i   = par;
        test_token_i    = tok;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R13 reset state
        check("R13", "valid", valid_o, 0);
        check("R13", "phase", phase_o, 0);
        check("R13", "pending", pending_o, 0);
        check("R13", "tx", tx_o, 0);
        check("R13", "err", err_o, 0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i].op, VEC[i].cnt);
            check(vec_tag(i), "phase",    phase_o,      VEC[i].phase);
            check(vec_tag(i), "pending",  pending_o,    VEC[i].pend);
            check(vec_tag(i), "expected", expected_o,   VEC[i].expc);
            check(vec_tag(i), "tx",       tx_o,         VEC[i].tx);
            check(vec_tag(i), "valid",    valid_o,      VEC[i].vld);
            check(vec_tag(i), "err",      err_o,        VEC[i].err);
            check(vec_tag(i), "uflow",    uflow_o,      VEC[i].uf);
            check(vec_tag(i), "close",    phase_done_o, VEC[i].done);
        end

        // State now: phase 1, pending 3, expected 3, tx 0
        // R9 parity and token tests before the close
        probe(1'b0, 1'b1, '0);
        check("R9", "parity of open phase", test_done_o, 0);
        probe(1'b0, 1'b0, '0);
        check("R9", "parity of closed phase", test_done_o, 1);
        probe(1'b1, 1'b0, 8'd1);
        check("R9", "token of open phase", test_done_o, 0);

        // R8 token returned by the closing arrive
        issue(4'd3, 32'd3);
        check("R8", "token value", token_o, 1);
        check("R8", "token pulse", token_vld_o, 1);
        check("R5", "phase after close", phase_o, 2);

        probe(1'b1, 1'b0, 8'd1);
        check("R9", "token after close", test_done_o, 1);
        probe(1'b0, 1'b0, '0);
        check("R9", "parity now open", test_done_o, 0);
        probe(1'b0, 1'b1, '0);
        check("R9", "parity now closed", test_done_o, 1);

        // R10 code 0 has no effect, unknown code is an error
        issue(4'd0, 32'd7);
        check("R10", "nop err", err_o, 0);
        check("R10", "nop pending", pending_o, 3);
        check("R10", "nop token pulse", token_vld_o, 0);
        issue(4'd12, 32'd1);
        check("R10", "unknown code err", err_o, 1);
        check("R10", "unknown code pending", pending_o, 3);

        // R3 expect-tx takes full 32-bit operand
        issue(4'd5, 32'h8000_0000);
        check("R3", "wide tx", tx_o, 64'h8000_0000);

        // R9 disarmed object reports nothing closed
        issue(4'd2, 32'd0);
        probe(1'b0, 1'b1, '0);
        check("R9", "disarmed test", test_done_o, 0);

        // R13 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R13", "valid after reset", valid_o, 0);
        check("R13", "tx after reset", tx_o, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule